// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block holds several independent down-counting timer channels behind a small word-addressed register port. Each channel keeps a reload value, a live count and a control word. One shared run register carries an enable bit per channel. A running channel counts down on ticks from one of three kinds of source. The first kind is a divided version of the block clock, with five divide ratios. The second is a pulse input from a real-time clock. The third is a pulse input from an external source.

When a tick arrives while the count is already zero, the channel reloads from its reload register. It then sets a sticky underflow flag. Only software can clear that flag, and software can never set it. Each channel drives one interrupt line, which is high whenever both the flag and the channel's interrupt enable are set. Software programs the reload value, the start count and the source, then sets the run bit. It takes the interrupt and writes the control word back with the flag bit at 0.

Top module: `tmr3_unit`

## Requirements
- R1: After reset, every reload and count register reads all ones, every control word and the run register read 0, and every interrupt line is low.
- R2: Register map, byte addresses: the run register is at 0x00, with bit n enabling channel n. Channel n has its reload register at 0x04+12n, its count at 0x08+12n and its control word at 0x0C+12n. The control word keeps bits 2:0 (source select), bit 5 (interrupt enable) and bit 8 (underflow flag). All other control bits read 0.
- R3: Source select codes 0 to 4 count every 4, 16, 64, 256 and 1024 clocks. The divider phase is held at zero while the channel is stopped, so the first decrement lands a full period after the run bit is set.
- R4: Source select 6 counts one step for each clock cycle in which `rtc_tick` is high. Select 7 does the same with `ext_tick`. Select 5 never counts.
- R5: Each tick decrements a nonzero count. A tick at count 0 loads the reload value and sets the underflow flag, so an underflow follows count+1 ticks.
- R6: While a channel's run bit is 0, its count holds its value.
- R7: A count-register write takes priority over a tick in the same cycle. On a running channel it also restarts the divider phase from zero.
- R8: A control write with bit 8 = 0 clears the underflow flag. A control write with bit 8 = 1 leaves the flag unchanged and never sets it.
- R9: If an underflow and a control write clearing the flag fall in the same cycle, the flag ends up set.
- R10: `irq[n]` is high exactly when channel n has both its underflow flag and its interrupt enable set. It falls in the cycle after either one is cleared.
- R11: Channels are independent: running or writing one channel leaves the others' registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the divider base |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW (6) | Byte address of the register |
| bus_wdata | input | CW (32) | Write data |
| bus_rdata | output | CW (32) | Read data of the addressed register, combinational |
| rtc_tick | input | 1 | Real-time-clock tick pulse, synchronous to clk |
| ext_tick | input | 1 | External tick pulse, synchronous to clk |
| irq | output | NCH (3) | Per-channel underflow interrupt |

## Verification
The bench builds the block with its default parameters: three channels, 32-bit counters and a 6-bit address. With these values the full register map is present, including the 12-byte stride reaching channel 2's control word at 0x24. The largest divide ratio of 1024 costs only about a thousand cycles, so the bench can time every prescaled underflow edge exactly. The same build also reaches the case where an underflow and a flag-clearing write land in one cycle, as well as independence across all three channels.

// File: rtl/tmr3_pkg.sv
`timescale 1ns/1ps
package tmr3_pkg;

  // Width of the prescale phase counter: log2 of the largest divide ratio.
  localparam int unsigned PS_W = 10;

  localparam int unsigned UNF_BIT  = 8;
  localparam int unsigned UNIE_BIT = 5;

  typedef enum logic [2:0] {
    SRC_DIV4    = 3'd0,
    SRC_DIV16   = 3'd1,
    SRC_DIV64   = 3'd2,
    SRC_DIV256  = 3'd3,
    SRC_DIV1024 = 3'd4,
    SRC_NONE    = 3'd5,
    SRC_RTC     = 3'd6,
    SRC_EXT     = 3'd7
  } src_sel_e;

  // Low phase bits that must all be one for a prescaled tick.
  function automatic logic [PS_W-1:0] phase_mask(input src_sel_e s);
    case (s)
      SRC_DIV4:    phase_mask = PS_W'(3);
      SRC_DIV16:   phase_mask = PS_W'(15);
      SRC_DIV64:   phase_mask = PS_W'(63);
      SRC_DIV256:  phase_mask = PS_W'(255);
      SRC_DIV1024: phase_mask = PS_W'(1023);
      default:     phase_mask = '0;
    endcase
  endfunction

endpackage

// File: rtl/tmr3_tick.sv
`timescale 1ns/1ps
module tmr3_tick
  import tmr3_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [2:0] sel_i,
  input  logic       rtc_tick_i,
  input  logic       ext_tick_i,
  output logic       tick_o
);

  logic [PS_W-1:0] phase_q, phase_d;
  logic [PS_W-1:0] mask;
  src_sel_e        sel;

  assign sel  = src_sel_e'(sel_i);
  assign mask = phase_mask(sel);

  always_comb begin
    if (!run_i || restart_i) phase_d = '0;
    else                     phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  always_comb begin
    tick_o = 1'b0;
    if (run_i && !restart_i) begin
      case (sel)
        SRC_RTC:  tick_o = rtc_tick_i;
        SRC_EXT:  tick_o = ext_tick_i;
        SRC_NONE: tick_o = 1'b0;
        default:  tick_o = ((phase_q & mask) == mask);
      endcase
    end
  end

  // R3
  stopped_phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (phase_q == '0));

  // R4
  reserved_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_NONE) |-> !tick_o);

endmodule

// File: rtl/tmr3_chan.sv
`timescale 1ns/1ps
module tmr3_chan
  import tmr3_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          rld_we_i,
  input  logic          cnt_we_i,
  input  logic          ctl_we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rld_o,
  output logic [CW-1:0] cnt_o,
  output logic [2:0]    sel_o,
  output logic          unie_o,
  output logic          unf_o
);

  logic [CW-1:0] rld_q, rld_d, cnt_q, cnt_d;
  logic [2:0]    sel_q, sel_d;
  logic          unie_q, unie_d, unf_q, unf_d;
  logic          uf_evt;

  assign uf_evt = tick_i && !cnt_we_i && (cnt_q == '0);

  always_comb begin
    rld_d  = rld_we_i ? wdata_i : rld_q;
    cnt_d  = cnt_q;
    if (cnt_we_i)            cnt_d = wdata_i;
    else if (uf_evt)         cnt_d = rld_q;
    else if (tick_i)         cnt_d = cnt_q - 1'b1;
    sel_d  = ctl_we_i ? wdata_i[2:0] : sel_q;
    unie_d = ctl_we_i ? wdata_i[UNIE_BIT] : unie_q;
    unf_d  = uf_evt | (ctl_we_i ? (unf_q & wdata_i[UNF_BIT]) : unf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q  <= '1;
      cnt_q  <= '1;
      sel_q  <= '0;
      unie_q <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      rld_q  <= rld_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      unie_q <= unie_d;
      unf_q  <= unf_d;
    end
  end

  assign rld_o  = rld_q;
  assign cnt_o  = cnt_q;
  assign sel_o  = sel_q;
  assign unie_o = unie_q;
  assign unf_o  = unf_q;

  // R5
  reload_on_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && (cnt_q == '0) && !cnt_we_i && !rld_we_i) |=> (unf_q && (cnt_q == rld_q)));

  // R6
  frozen_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !cnt_we_i) |=> $stable(cnt_q));

  // R8
  flag_never_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unf_q && !(tick_i && (cnt_q == '0))) |=> !unf_q);

  // R9
  underflow_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && (cnt_q == '0) && !cnt_we_i) |=> unf_q);

endmodule

// File: rtl/tmr3_regs.sv
`timescale 1ns/1ps
module tmr3_regs #(
  parameter int unsigned NCH = 3,
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [NCH-1:0]          run_wdata_i,
  input  logic [NCH-1:0][CW-1:0]  rld_i,
  input  logic [NCH-1:0][CW-1:0]  cnt_i,
  input  logic [NCH-1:0][CW-1:0]  ctl_i,
  output logic [NCH-1:0]          run_o,
  output logic [NCH-1:0]          rld_we_o,
  output logic [NCH-1:0]          cnt_we_o,
  output logic [NCH-1:0]          ctl_we_o,
  output logic [CW-1:0]           rdata_o
);

  localparam int unsigned STRIDE = 12;
  localparam int unsigned CH0    = 4;

  logic [NCH-1:0] run_q, run_d;
  logic           run_sel;

  assign run_sel = (addr_i == AW'(0));

  always_comb run_d = (wr_i && run_sel) ? run_wdata_i : run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign run_o = run_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    localparam int unsigned BASE = CH0 + STRIDE * ch;
    assign rld_we_o[ch] = wr_i && (addr_i == AW'(BASE));
    assign cnt_we_o[ch] = wr_i && (addr_i == AW'(BASE + 4));
    assign ctl_we_o[ch] = wr_i && (addr_i == AW'(BASE + 8));
  end

  always_comb begin
    rdata_o = '0;
    if (run_sel) rdata_o = CW'(run_q);
    for (int ch = 0; ch < NCH; ch++) begin
      if (addr_i == AW'(CH0 + STRIDE * ch))     rdata_o = rld_i[ch];
      if (addr_i == AW'(CH0 + STRIDE * ch + 4)) rdata_o = cnt_i[ch];
      if (addr_i == AW'(CH0 + STRIDE * ch + 8)) rdata_o = ctl_i[ch];
    end
  end

  // R2
  one_write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rld_we_o, cnt_we_o, ctl_we_o}) <= 1);

endmodule

// File: rtl/tmr3_unit.sv
`timescale 1ns/1ps
module tmr3_unit #(
  parameter int unsigned NCH = 3,
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  input  logic           rtc_tick,
  input  logic           ext_tick,
  output logic [NCH-1:0] irq
);

  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end

  assign rst_ni = rst_sync[1];

  logic [NCH-1:0]         run, rld_we, cnt_we, ctl_we, tick, unie, unf;
  logic [NCH-1:0][CW-1:0] rld, cnt, ctl;
  logic [NCH-1:0][2:0]    sel;

  tmr3_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_ni),
    .wr_i        (bus_wr),
    .addr_i      (bus_addr),
    .run_wdata_i (bus_wdata[NCH-1:0]),
    .rld_i       (rld),
    .cnt_i       (cnt),
    .ctl_i       (ctl),
    .run_o       (run),
    .rld_we_o    (rld_we),
    .cnt_we_o    (cnt_we),
    .ctl_we_o    (ctl_we),
    .rdata_o     (bus_rdata)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tmr3_tick u_tick (
      .clk        (clk),
      .rst_n      (rst_ni),
      .run_i      (run[ch]),
      .restart_i  (cnt_we[ch]),
      .sel_i      (sel[ch]),
      .rtc_tick_i (rtc_tick),
      .ext_tick_i (ext_tick),
      .tick_o     (tick[ch])
    );

    tmr3_chan #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_ni),
      .run_i    (run[ch]),
      .tick_i   (tick[ch]),
      .rld_we_i (rld_we[ch]),
      .cnt_we_i (cnt_we[ch]),
      .ctl_we_i (ctl_we[ch]),
      .wdata_i  (bus_wdata),
      .rld_o    (rld[ch]),
      .cnt_o    (cnt[ch]),
      .sel_o    (sel[ch]),
      .unie_o   (unie[ch]),
      .unf_o    (unf[ch])
    );

    assign ctl[ch] = CW'({unf[ch], 2'b00, unie[ch], 2'b00, sel[ch]});
    assign irq[ch] = unf[ch] & unie[ch];

    // R10
    irq_drops_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      (ctl_we[ch] && !bus_wdata[8] && !tick[ch]) |=> !irq[ch]);
  end

endmodule

// File: tb/tmr3_unit_test.sv
`timescale 1ns/1ps
module tmr3_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rtc_tick, ext_tick;
  logic [2:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr3_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_tick(rtc_tick),
    .ext_tick(ext_tick), .irq(irq)
  );

  localparam logic [5:0] A_RUN = 6'h00;
  function automatic logic [5:0] a_rld(int n); return 6'(4 + 12 * n); endfunction
  function automatic logic [5:0] a_cnt(int n); return 6'(8 + 12 * n); endfunction
  function automatic logic [5:0] a_ctl(int n); return 6'(12 + 12 * n); endfunction

  // {address, write data, expected readback}
  typedef struct packed { logic [5:0] a; logic [31:0] wd; logic [31:0] exp; } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{6'h04, 32'h1234_5678, 32'h1234_5678},
    '{6'h10, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    '{6'h1C, 32'h0000_0007, 32'h0000_0007},
    '{6'h0C, 32'hFFFF_FFFF, 32'h0000_0027},
    '{6'h0C, 32'h0000_0000, 32'h0000_0000},
    '{6'h14, 32'h0000_0055, 32'h0000_0055},
    '{6'h24, 32'h0000_0125, 32'h0000_0025},
    '{6'h00, 32'h0000_0006, 32'h0000_0006}
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rtc_tick = 1'b0; ext_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    for (int n = 0; n < 3; n++) begin
      rd(a_rld(n), v); check("R1 reload", v, 32'hFFFF_FFFF);
      rd(a_cnt(n), v); check("R1 count", v, 32'hFFFF_FFFF);
      rd(a_ctl(n), v); check("R1 control", v, 32'h0);
    end
    rd(A_RUN, v); check("R1 run", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2 R8 map and field table
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].a, VECS[i].wd);
      rd(VECS[i].a, v);
      check("R2 table readback", v, VECS[i].exp);
    end
    rd(a_cnt(0), v); check("R11 ch0 count untouched", v, 32'hFFFF_FFFF);

    // R3 R5 R10: /4, count 2, reload 5
    do_reset();
    wr(a_rld(0), 32'd5); wr(a_cnt(0), 32'd2); wr(a_ctl(0), 32'h20);
    wr(A_RUN, 32'h1);
    idle(11);
    rd(a_cnt(0), v); check("R5 count before underflow", v, 32'd0);
    check("R10 irq low before underflow", 32'(irq), 32'h0);
    idle(1);
    rd(a_cnt(0), v); check("R5 reload on underflow", v, 32'd5);
    rd(a_ctl(0), v); check("R5 flag set", v, 32'h120);
    check("R10 irq high", 32'(irq), 32'h1);
    // R8: writing 1 keeps, writing 0 clears
    wr(a_ctl(0), 32'h120);
    rd(a_ctl(0), v); check("R8 write one keeps flag", v, 32'h120);
    wr(a_ctl(0), 32'h20);
    rd(a_ctl(0), v); check("R8 write zero clears flag", v, 32'h20);
    check("R10 irq drops after clear", 32'(irq), 32'h0);

    // R3 /16 without enable, and /1024 on ch2
    do_reset();
    wr(a_rld(0), 32'd9); wr(a_cnt(0), 32'd0); wr(a_ctl(0), 32'h1);
    wr(a_cnt(2), 32'd0); wr(a_ctl(2), 32'h4);
    wr(A_RUN, 32'h5);
    idle(15);
    rd(a_cnt(0), v); check("R3 div16 no tick yet", v, 32'd0);
    idle(1);
    rd(a_cnt(0), v); check("R3 div16 underflow", v, 32'd9);
    rd(a_ctl(0), v); check("R3 div16 flag", v, 32'h101);
    check("R10 no irq without enable", 32'(irq), 32'h0);
    idle(1023 - 16);
    rd(a_cnt(2), v); check("R3 div1024 no tick yet", v, 32'd0);
    idle(1);
    rd(a_cnt(2), v); check("R3 div1024 underflow", v, 32'hFFFF_FFFF);
    rd(a_cnt(1), v); check("R11 ch1 untouched", v, 32'hFFFF_FFFF);

    // R6 stop freezes
    do_reset();
    wr(a_cnt(0), 32'd100); wr(a_ctl(0), 32'h0);
    wr(A_RUN, 32'h1);
    idle(40);
    rd(a_cnt(0), v); check("R6 counted while running", v, 32'd90);
    wr(A_RUN, 32'h0);
    idle(20);
    rd(a_cnt(0), v); check("R6 frozen when stopped", v, 32'd90);

    // R7 count write restarts phase
    do_reset();
    wr(a_cnt(0), 32'd100); wr(a_ctl(0), 32'h0);
    wr(A_RUN, 32'h1);
    idle(2);
    wr(a_cnt(0), 32'd50);
    idle(3);
    rd(a_cnt(0), v); check("R7 phase restarted", v, 32'd50);
    idle(1);
    rd(a_cnt(0), v); check("R7 first tick after restart", v, 32'd49);

    // R4 tick sources
    do_reset();
    wr(a_cnt(0), 32'd3); wr(a_ctl(0), 32'h6);
    wr(a_cnt(1), 32'd3); wr(a_ctl(1), 32'h7);
    wr(a_cnt(2), 32'd3); wr(a_ctl(2), 32'h5);
    wr(A_RUN, 32'h7);
    rtc_tick = 1'b1; @(negedge clk); rtc_tick = 1'b0;
    rd(a_cnt(0), v); check("R4 rtc counts ch0", v, 32'd2);
    rd(a_cnt(1), v); check("R4 rtc ignored by ext ch1", v, 32'd3);
    ext_tick = 1'b1; @(negedge clk); ext_tick = 1'b0;
    rd(a_cnt(1), v); check("R4 ext counts ch1", v, 32'd2);
    rd(a_cnt(0), v); check("R4 ext ignored by rtc ch0", v, 32'd2);
    idle(50);
    rd(a_cnt(2), v); check("R4 reserved code never counts", v, 32'd3);

    // R9 underflow beats clear in the same cycle
    wr(a_cnt(0), 32'd0); wr(a_ctl(0), 32'h26);
    rtc_tick = 1'b1; @(negedge clk); rtc_tick = 1'b0;
    rd(a_ctl(0), v); check("R9 first underflow", v, 32'h126);
    wr(a_cnt(0), 32'd0);
    rtc_tick = 1'b1;
    wr(a_ctl(0), 32'h26);
    rtc_tick = 1'b0;
    rd(a_ctl(0), v); check("R9 flag stays set", v, 32'h126);
    check("R9 irq stays high", 32'(irq), 32'h1);
    wr(a_ctl(0), 32'h06);
    check("R10 irq drops when enable cleared", 32'(irq), 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule